// File: doc/BRIEF.md
# Strap-Selected Boot Configuration Loader

This block sets the boot parameters of a chip when it leaves reset. While the active-low reset is held, it samples three strap pins on every rising clock edge. The value captured at the last edge before reset rises selects one of eight boot options, and later changes on the pins have no effect. Six of the options have fixed parameter sets. The block places the matching set in four 32-bit configuration words and reports completion one clock after reset is released.

The two remaining options each name an EEPROM device address. For these, the block acts as a small I2C master on open-drain lines. It performs a random read of sixteen bytes starting at word address zero and packs the bytes into the four configuration words. Completion is reported only after the closing STOP. If the device or the word address is not acknowledged, the block ends the transfer with a STOP, raises an error flag and falls back to the first fixed parameter set. SCL is derived from the system clock, and each quarter of an SCL bit period lasts `QTR_CYC` clocks.

Top module: `boot_cfg_loader`

## Requirements
- R1: The strap pins are sampled at every rising clock edge while `rst_ni` is low. The option is taken from the value captured at the last such edge, and strap changes after reset release have no effect.
- R2: Strap codes 3'b000 to 3'b101 select the fixed options. Code 3'b110 selects an EEPROM load with device byte 0xA8, and code 3'b111 selects one with device byte 0xA4. In both cases the write byte is the device byte with bit 0 clear and the read byte is the device byte with bit 0 set.
- R3: For a fixed code c, word k (k = 0..3) is {8'hC0 | c, 8'(k), 16'hA55A}. `done_o` is high after the first rising edge following reset release, and neither bus line is ever pulled low.
- R4: An EEPROM load sends START, the write byte, exactly one word-address byte 0x00, a repeated START and the read byte, so the bus carries exactly two START conditions.
- R5: The master acknowledges the first fifteen data bytes, answers the sixteenth with NACK and then issues STOP. `done_o` is still low when the STOP occurs and rises afterwards.
- R6: Data bytes are packed big-endian. Byte i goes to word i/4 at bits [31-8*(i%4) -: 8].
- R7: If the write byte, the word-address byte or the read byte is not acknowledged, the block issues a STOP and sets `err_o` together with `done_o`. All four words then take the code 3'b000 values given in R3.
- R8: SDA changes only while SCL is low, except during START and STOP. Every SCL high pulse after the first START lasts 2*`QTR_CYC` clocks.
- R9: Once set, `done_o`, `err_o` and the configuration words hold their values until the next reset. During reset `done_o` and `err_o` are low and both bus lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset; straps sampled while low |
| strap_i | input | 3 | Boot option strap pins |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| cfg_o | output | 32*N_WORDS | Configuration words, word k at [32k+31:32k] |
| done_o | output | 1 | Boot parameters valid |
| err_o | output | 1 | EEPROM load aborted, defaults applied |

## Verification
The error paths are the hardest to reach from the ports. A NACK only occurs when the far side of the bus refuses a byte, and the refusal of the word-address byte comes after a device byte that was acknowledged. The bench therefore includes an EEPROM model with a settable device address and an option to refuse the word address. Some table rows pair a strap code with a device at the other address, and others make the model reject the word address. The same model counts START conditions, data acknowledgements and the level of `done_o` at the STOP. This shows that only one address byte is sent and that completion follows the STOP.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;
  localparam int STRAP_W = 3;
  localparam logic [7:0] DEV_LO = 8'hA8;
  localparam logic [7:0] DEV_HI = 8'hA4;

  typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_WRITE, CMD_READ} i2c_cmd_e;

  typedef enum logic [3:0] {
    S_INIT, S_START, S_DEVW, S_WADDR, S_RSTART, S_DEVR, S_READ, S_STOP, S_FIN
  } seq_st_e;

  function automatic logic uses_eeprom(logic [STRAP_W-1:0] s);
    return s[2] & s[1];
  endfunction

  function automatic logic [7:0] dev_byte(logic [STRAP_W-1:0] s);
    return s[0] ? DEV_HI : DEV_LO;
  endfunction

  function automatic logic [31:0] dflt_word(logic [STRAP_W-1:0] opt, logic [1:0] k);
    return {5'b11000, opt, 6'd0, k, 16'hA55A};
  endfunction
endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] strap_i,
  output logic [W-1:0] strap_o
);
  logic [W-1:0] strap_q;

  // tracks pins only while reset is held; frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) strap_q <= strap_i;
  end

  assign strap_o = strap_q;
endmodule

// File: rtl/boot_i2c_bit_engine.sv
module boot_i2c_bit_engine
  import boot_cfg_pkg::*;
#(
  parameter int QTR_CYC = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      go_i,
  input  i2c_cmd_e  cmd_i,
  input  logic [7:0] tx_i,
  input  logic      ack_tx_i,
  input  logic      sda_i,
  output logic      done_o,
  output logic [7:0] rx_o,
  output logic      ack_rx_o,
  output logic      scl_oe_o,
  output logic      sda_oe_o
);
  localparam int DW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(QTR_CYC - 1);

  logic          busy_q, done_q, ack_tx_q, ack_rx_q;
  logic          scl_q, sda_q;   // 1 = released
  i2c_cmd_e      cmd_q;
  logic [1:0]    q_q;
  logic [3:0]    bit_q;
  logic [7:0]    sh_q;
  logic [DW-1:0] div_q;
  logic          qtick;

  assign qtick = busy_q && (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      cmd_q    <= CMD_START;
      q_q      <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      ack_tx_q <= 1'b0;
      ack_rx_q <= 1'b0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      div_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q   <= 1'b1;
          cmd_q    <= cmd_i;
          sh_q     <= tx_i;
          ack_tx_q <= ack_tx_i;
          q_q      <= '0;
          bit_q    <= '0;
          div_q    <= '0;
        end
      end else if (!qtick) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        q_q   <= q_q + 1'b1;
        case (cmd_q)
          CMD_START: begin
            case (q_q)
              2'd0: sda_q <= 1'b1;
              2'd1: scl_q <= 1'b1;
              2'd2: sda_q <= 1'b0;
              default: begin
                scl_q  <= 1'b0;
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end
            endcase
          end
          CMD_STOP: begin
            case (q_q)
              2'd0: sda_q <= 1'b0;
              2'd1: scl_q <= 1'b1;
              2'd2: sda_q <= 1'b1;
              default: begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end
            endcase
          end
          default: begin
            case (q_q)
              2'd0: begin
                if (bit_q == 4'd8) sda_q <= (cmd_q == CMD_READ) ? !ack_tx_q : 1'b1;
                else               sda_q <= (cmd_q == CMD_WRITE) ? sh_q[7] : 1'b1;
              end
              2'd1: scl_q <= 1'b1;
              2'd2: begin
                if (bit_q == 4'd8) ack_rx_q <= !sda_i;
                else               sh_q     <= {sh_q[6:0], sda_i};
              end
              default: begin
                scl_q <= 1'b0;
                if (bit_q == 4'd8) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                end else begin
                  bit_q <= bit_q + 1'b1;
                end
              end
            endcase
          end
        endcase
      end
    end
  end

  assign done_o   = done_q;
  assign rx_o     = sh_q;
  assign ack_rx_o = ack_rx_q;
  assign scl_oe_o = !scl_q;
  assign sda_oe_o = !sda_q;

  AST_GO_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_q); // R4
  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && (cmd_q == CMD_WRITE || cmd_q == CMD_READ) && scl_q && $past(scl_q))
      |-> $stable(sda_q)); // R8
  AST_SCL_LOW_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && cmd_q != CMD_STOP) |-> !scl_q); // R8
endmodule

// File: rtl/boot_cfg_seq.sv
module boot_cfg_seq
  import boot_cfg_pkg::*;
#(
  parameter int N_WORDS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      eeprom_i,
  input  logic [STRAP_W-1:0]        opt_i,
  input  logic [7:0]                dev_i,
  input  logic                      eng_done_i,
  input  logic                      eng_ack_i,
  input  logic [7:0]                eng_rx_i,
  output logic                      go_o,
  output i2c_cmd_e                  cmd_o,
  output logic [7:0]                tx_o,
  output logic                      ack_tx_o,
  output logic [N_WORDS-1:0][31:0]  cfg_o,
  output logic                      done_o,
  output logic                      err_o
);
  localparam int N_BYTES = N_WORDS * 4;
  localparam int IDX_W = $clog2(N_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BYTES - 1);

  seq_st_e                   st_q;
  logic                      wait_q, err_pend_q, done_q, err_q, bus_st;
  logic [IDX_W-1:0]          idx_q;
  logic [N_WORDS-1:0][31:0]  cfg_q;

  always_comb begin
    bus_st   = st_q inside {S_START, S_DEVW, S_WADDR, S_RSTART, S_DEVR, S_READ, S_STOP};
    go_o     = bus_st && !wait_q;
    cmd_o    = CMD_WRITE;
    tx_o     = dev_i & 8'hFE;
    ack_tx_o = (idx_q != LAST);
    case (st_q)
      S_START, S_RSTART: cmd_o = CMD_START;
      S_STOP:            cmd_o = CMD_STOP;
      S_WADDR:           tx_o  = 8'h00;
      S_DEVR:            tx_o  = dev_i | 8'h01;
      S_READ:            cmd_o = CMD_READ;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_INIT;
      wait_q     <= 1'b0;
      err_pend_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      idx_q      <= '0;
      cfg_q      <= '0;
    end else begin
      if (go_o) wait_q <= 1'b1;
      if (st_q == S_INIT) begin
        if (eeprom_i) begin
          st_q <= S_START;
        end else begin
          for (int k = 0; k < N_WORDS; k++) cfg_q[k] <= dflt_word(opt_i, 2'(k));
          done_q <= 1'b1;
          st_q   <= S_FIN;
        end
      end else if (eng_done_i) begin
        wait_q <= 1'b0;
        case (st_q)
          S_START:  st_q <= S_DEVW;
          S_DEVW, S_WADDR, S_DEVR: begin
            if (!eng_ack_i) begin
              err_pend_q <= 1'b1;
              st_q       <= S_STOP;
            end else if (st_q == S_DEVW) st_q <= S_WADDR;
            else if (st_q == S_WADDR)    st_q <= S_RSTART;
            else                         st_q <= S_READ;
          end
          S_RSTART: st_q <= S_DEVR;
          S_READ: begin
            cfg_q[idx_q[IDX_W-1:2]][{~idx_q[1:0], 3'b000} +: 8] <= eng_rx_i;
            if (idx_q == LAST) st_q <= S_STOP;
            else               idx_q <= idx_q + 1'b1;
          end
          S_STOP: begin
            st_q   <= S_FIN;
            done_q <= 1'b1;
            if (err_pend_q) begin
              err_q <= 1'b1;
              for (int k = 0; k < N_WORDS; k++) cfg_q[k] <= dflt_word('0, 2'(k));
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> done_q); // R7
  AST_NO_CMD_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !go_o); // R5
endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader
  import boot_cfg_pkg::*;
#(
  parameter int N_WORDS = 4,
  parameter int QTR_CYC = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2:0]             strap_i,
  input  logic                   sda_i,
  output logic                   scl_oe_o,
  output logic                   sda_oe_o,
  output logic [N_WORDS*32-1:0]  cfg_o,
  output logic                   done_o,
  output logic                   err_o
);
  logic [STRAP_W-1:0]       strap;
  logic                     eeprom;
  logic [7:0]               dev;
  logic                     go, ack_tx, eng_done, eng_ack;
  i2c_cmd_e                 cmd;
  logic [7:0]               tx, rx;
  logic [N_WORDS-1:0][31:0] cfg;

  boot_strap_latch #(.W(STRAP_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (strap_i),
    .strap_o (strap)
  );

  assign eeprom = uses_eeprom(strap);
  assign dev    = dev_byte(strap);

  boot_i2c_bit_engine #(.QTR_CYC(QTR_CYC)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .cmd_i    (cmd),
    .tx_i     (tx),
    .ack_tx_i (ack_tx),
    .sda_i    (sda_i),
    .done_o   (eng_done),
    .rx_o     (rx),
    .ack_rx_o (eng_ack),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o)
  );

  boot_cfg_seq #(.N_WORDS(N_WORDS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eeprom_i   (eeprom),
    .opt_i      (strap),
    .dev_i      (dev),
    .eng_done_i (eng_done),
    .eng_ack_i  (eng_ack),
    .eng_rx_i   (rx),
    .go_o       (go),
    .cmd_o      (cmd),
    .tx_o       (tx),
    .ack_tx_o   (ack_tx),
    .cfg_o      (cfg),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  assign cfg_o = cfg;

  AST_STRAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(strap)); // R1
  AST_BUS_IDLE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eeprom |-> (!scl_oe_o && !sda_oe_o)); // R3
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(cfg_o)); // R9
  AST_ERR_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cfg[0] == dflt_word('0, 2'd0))); // R7
endmodule

// File: tb/boot_cfg_loader_bench.sv
module boot_cfg_loader_bench;
  localparam int N_WORDS = 4;
  localparam int QTR_CYC = 4;
  localparam int N_ROWS = 10;
  // row: {strap[2:0], device addr7[6:0], refuse word address, expect error}
  localparam logic [11:0] ROWS [N_ROWS] = '{
    {3'd0, 7'h54, 1'b0, 1'b0}, {3'd1, 7'h54, 1'b0, 1'b0},
    {3'd2, 7'h54, 1'b0, 1'b0}, {3'd3, 7'h54, 1'b0, 1'b0},
    {3'd4, 7'h54, 1'b0, 1'b0}, {3'd5, 7'h54, 1'b0, 1'b0},
    {3'd6, 7'h54, 1'b0, 1'b0}, {3'd7, 7'h52, 1'b0, 1'b0},
    {3'd6, 7'h52, 1'b0, 1'b1}, {3'd7, 7'h52, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] strap = 3'd0;
  logic scl_oe, sda_oe, done, err;
  logic [N_WORDS*32-1:0] cfg;
  logic sl_oe = 1'b0;
  logic scl_w, sda_w;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  assign scl_w = !scl_oe;
  assign sda_w = !(sda_oe || sl_oe);

  boot_cfg_loader #(.N_WORDS(N_WORDS), .QTR_CYC(QTR_CYC)) u_boot_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .cfg_o(cfg), .done_o(done), .err_o(err)
  );

  function automatic logic [7:0] mem_b(int i);
    return 8'((i % 16) * 29 + 7);
  endfunction

  function automatic logic [31:0] exp_fixed(logic [2:0] c, int k);
    return {8'hC0 | {5'd0, c}, 8'(k), 16'hA55A};
  endfunction

  function automatic logic [31:0] exp_eep(int k);
    return {mem_b(4*k), mem_b(4*k+1), mem_b(4*k+2), mem_b(4*k+3)};
  endfunction

  // EEPROM model
  logic [6:0] sl_addr = 7'h54;
  logic sl_nack_w = 1'b0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  int ph = 0, bitn = 0, ptr = 0;
  logic [7:0] sh = 8'd0, byte_t, last_devw = 8'd0, last_devr = 8'd0, waddr = 8'hFF;
  logic rw = 1'b0, mack = 1'b0, stop_done = 1'b0;
  int starts = 0, stops = 0, acks = 0, nacks = 0;
  time t_rise = 0, min_high = 1000000;

  always @(scl_w or sda_w) begin
    if (scl_w === 1'b1 && p_scl === 1'b1 && p_sda === 1'b1 && sda_w === 1'b0) begin
      ph = 1; bitn = -1; sl_oe = 1'b0; starts++;
    end else if (scl_w === 1'b1 && p_scl === 1'b1 && p_sda === 1'b0 && sda_w === 1'b1) begin
      ph = 0; sl_oe = 1'b0; stops++; stop_done = done;
    end else if (scl_w === 1'b1 && p_scl === 1'b0) begin
      t_rise = $time;
      if (ph >= 1 && ph <= 3) begin
        if (bitn >= 0 && bitn < 8 && ph != 3) sh = {sh[6:0], sda_w};
        if (bitn == 8 && ph == 3) begin
          mack = !sda_w;
          if (mack) acks++; else nacks++;
        end
      end
    end else if (scl_w === 1'b0 && p_scl === 1'b1) begin
      if ($time - t_rise < min_high && t_rise != 0) min_high = $time - t_rise;
      if (ph >= 1 && ph <= 3) begin
        if (bitn < 8) begin
          bitn++;
          if (bitn == 8) begin
            if (ph == 1) begin
              if (sh[0]) last_devr = sh; else last_devw = sh;
              if (sh[7:1] == sl_addr) begin sl_oe = 1'b1; rw = sh[0]; end
              else begin sl_oe = 1'b0; ph = 4; end
            end else if (ph == 2) begin
              waddr = sh; ptr = int'(sh);
              if (!sl_nack_w) sl_oe = 1'b1;
              else begin sl_oe = 1'b0; ph = 4; end
            end else begin
              sl_oe = 1'b0;
            end
          end else if (ph == 3 && bitn > 0) begin
            byte_t = mem_b(ptr); sl_oe = !byte_t[7-bitn];
          end
        end else begin
          bitn = 0;
          if (ph == 1) ph = rw ? 3 : 2;
          else if (ph == 2) ph = 4;
          else if (ph == 3) begin ptr++; if (!mack) ph = 4; end
          if (ph == 3) begin byte_t = mem_b(ptr); sl_oe = !byte_t[7]; end
          else sl_oe = 1'b0;
        end
      end
    end
    p_scl = scl_w; p_sda = sda_w;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && done !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic run_case(input logic [2:0] s, input logic [6:0] a, input logic nw, input logic ee);
    int st0, sp0, ak0, nk0;
    logic eep;
    logic [N_WORDS*32-1:0] snap;
    eep = s[2] & s[1];
    @(negedge clk);
    rst_n = 1'b0; strap = s; sl_addr = a; sl_nack_w = nw;
    repeat (3) @(negedge clk);
    st0 = starts; sp0 = stops; ak0 = acks; nk0 = nacks;
    chk("R9 reset done/err/bus", {28'd0, done, err, scl_oe, sda_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(eep ? "R5 done low at start" : "R3 done after first edge", {31'd0, done}, {31'd0, !eep});
    wait_done();
    chk("R3/R5 done reached", {31'd0, done}, 32'd1);
    chk("R7 err flag", {31'd0, err}, {31'd0, ee});
    for (int k = 0; k < N_WORDS; k++) begin
      if (!eep)    chk("R3 fixed word", cfg[32*k +: 32], exp_fixed(s, k));
      else if (ee) chk("R7 fallback word", cfg[32*k +: 32], exp_fixed(3'd0, k));
      else         chk("R6 packed word", cfg[32*k +: 32], exp_eep(k));
    end
    if (!eep) chk("R3 no bus START", starts - st0, 0);
    if (eep) chk("R2 write dev byte", {24'd0, last_devw}, s[0] ? 32'hA4 : 32'hA8);
    if (eep && !ee) begin
      chk("R2 read dev byte", {24'd0, last_devr}, s[0] ? 32'hA5 : 32'hA9);
      chk("R4 word address", {24'd0, waddr}, 32'h00);
      chk("R4 two STARTs", starts - st0, 2);
      chk("R5 data ACKs", acks - ak0, 15);
      chk("R5 final NACK", nacks - nk0, 1);
      chk("R5 done low at STOP", {31'd0, stop_done}, 32'd0);
    end
    if (ee) chk("R7 STOP after NACK", stops - sp0, 1);
    snap = cfg;
    strap = ~s;
    repeat (100) @(negedge clk);
    chk("R9 done held", {30'd0, done, err}, {30'd0, 1'b1, ee});
    chk("R9 word0 held", snap[31:0], cfg[31:0]);
    chk("R1 late strap ignored", cfg[127:96], snap[127:96]);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog cycles=%0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < N_ROWS; r++)
      run_case(ROWS[r][11:9], ROWS[r][8:2], ROWS[r][1], ROWS[r][0]);

    // R1: last edge before release wins (eeprom code overridden by fixed code)
    @(negedge clk);
    rst_n = 1'b0; strap = 3'd7;
    repeat (3) @(negedge clk);
    strap = 3'd2;
    @(negedge clk);
    rst_n = 1'b1; strap = 3'd6;
    repeat (5) @(negedge clk);
    chk("R1 last sample fixed C", cfg[31:0], exp_fixed(3'd2, 0));
    chk("R1 no eeprom access", {31'd0, scl_oe}, 32'd0);

    // R1: fixed code overridden by eeprom code at the last edge
    @(negedge clk);
    rst_n = 1'b0; strap = 3'd1; sl_addr = 7'h52; sl_nack_w = 1'b0;
    repeat (3) @(negedge clk);
    strap = 3'd7;
    @(negedge clk);
    rst_n = 1'b1; strap = 3'd0;
    wait_done();
    chk("R1 last sample eeprom H", cfg[127:96], exp_eep(3));
    chk("R1 no error", {31'd0, err}, 32'd0);

    chk("R8 SCL high width ns", 32'(min_high), 32'(2 * QTR_CYC * 10));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule